// File: doc/BRIEF.md
# Breakpoint Halt Controller

This block is the debug-stop logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has branch delay slots. It holds a small table of armed instruction addresses. Every fetch is compared against that table. A hit is not acted on at fetch. Instead a tag is attached to the instruction and follows it down the pipeline. When the tagged instruction reaches the memory stage, the block takes effect: it blocks the instruction's memory and peripheral effects, discards it and everything younger, stalls fetch, and stops once the writeback stage has emptied. A break instruction flagged by the decoder is handled along the same path, but it restarts after itself.

The block keeps a restart address while it is stopped. A resume request or a single-step request starts the pipeline again. The pipeline loads the restart address into its program counter. After a stop on an address match, the match is masked for exactly the first instruction fetched, so the stopped instruction can run. Single-step lets one instruction through and then stops again.

Fetch acceptance is a valid/ready handshake. An instruction enters decode on a cycle where `fetch_valid` and `fetch_ready` are both high. `fetch_ready` is low in these cases: while `advance` is low, in the cycle of a flush, while the pipeline drains, while the block is stopped, and after the one instruction of a single step has been taken. The pipeline must not count a fetch as issued unless both signals are high. All other pins are plain level signals.

Top module: `bkpt_halt_ctrl`

## Requirements
- R1: Writing an entry stores bits 31:2 of an address and an arm bit at the index given. A fetch is tagged when any armed entry equals bits 31:2 of `fetch_pc`.
- R2: A tag has no effect at fetch. `fetch_ready` stays high. With `advance` held high, `mem_suppress` rises exactly two cycles after the edge that accepted the tagged fetch.
- R3: While a tagged instruction is in the memory stage, `mem_suppress` and `flush_young` are high and `fetch_ready` is low. `flush_young` lasts one cycle.
- R4: `halted` rises on the first edge at which the writeback stage is empty after a flush. With `advance` high, that is one cycle after the flush. While `advance` is low it waits. `resume_pc` is the tagged instruction's address.
- R5: If `mem_dslot` is high when the tagged instruction is in the memory stage, `resume_pc` is the address of the instruction in writeback, which is the branch.
- R6: After a resume or step from an address-match stop, the first accepted fetch is never tagged, whatever its address. Every later fetch is matched normally.
- R7: When `id_break` is high while an instruction is in decode, that instruction is marked as a break. At the memory stage it flushes the younger stages and stops the pipeline like R4, without `mem_suppress`. `resume_pc` is its address plus 4.
- R8: A `step_req` while stopped allows exactly one accepted fetch. The block stops again once that instruction has left writeback (fetch edge plus four cycles). `resume_pc` is the `mem_next_pc` reported while that instruction was in the memory stage.
- R9: While `halted` is high, `fetch_ready` is low and `halted` stays high until `resume_req` or `step_req`. After either request it is low on the next cycle.
- R10: Reset clears all table entries, all tags and the one-shot mask. It leaves the block running, with `halted`, `flush_young` and `mem_suppress` low and `resume_pc` zero.
- R11: Unarmed entries never match. Bits 1:0 of `fetch_pc` do not take part in the comparison.
- R12: `fetch_ready` is low whenever `advance` is low. No fetch is accepted in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Write strobe for the address table |
| tbl_wr_idx | input | 2 | Entry to write |
| tbl_wr_word | input | 30 | Word address (bits 31:2) for the entry |
| tbl_wr_arm | input | 1 | Arm bit for the entry |
| fetch_valid | input | 1 | Pipeline offers an instruction at `fetch_pc` |
| fetch_ready | output | 1 | Controller lets the fetch enter decode |
| fetch_pc | input | 32 | Address of the offered instruction |
| advance | input | 1 | Pipeline stages move forward this cycle |
| id_break | input | 1 | Instruction now in decode is a break |
| mem_dslot | input | 1 | Memory-stage instruction sits in a delay slot |
| mem_next_pc | input | 32 | Next program-flow address of the memory-stage instruction |
| resume_req | input | 1 | Continue running (honoured while halted) |
| step_req | input | 1 | Run one instruction (honoured while halted) |
| mem_suppress | output | 1 | Block memory and peripheral effects of the memory-stage instruction |
| flush_young | output | 1 | Discard the memory-stage instruction and all younger ones |
| halted | output | 1 | Pipeline stopped |
| resume_pc | output | 32 | Address to restart fetch from |

## Verification
The hardest state to reach is an address match on a delay-slot instruction. Resuming from it restarts at the branch, so the one-shot mask is spent on the branch and the breakpoint fires again at once. The bench reaches this state by replaying a sweep over every table entry with `mem_dslot` held high, then resuming and checking that the second fetch after the resume is the one that stops. A stop taken while `advance` is low is also exercised, by dropping `advance` in the flush cycle so that the writeback stage is still occupied.

// File: rtl/bkpt_halt_pkg.sv
package bkpt_halt_pkg;
  localparam int PC_W = 32;

  typedef struct packed {
    logic            valid;
    logic [PC_W-1:0] pc;
    logic            bp;
    logic            brk;
  } stage_t;

  typedef enum logic [1:0] {S_RUN, S_DRAIN, S_HALT} run_e;
  typedef enum logic [1:0] {C_NONE, C_ADDR, C_BREAK, C_STEP} cause_e;
endpackage

// File: rtl/bkpt_match_table.sv
module bkpt_match_table
  import bkpt_halt_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-3:0]  wr_word,
  input  logic             wr_arm,
  input  logic [PC_W-3:0]  look_word,
  output logic             hit
);
  logic [N_ENT-1:0] eq;

  generate
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic            arm_q;
      logic [PC_W-3:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          arm_q  <= 1'b0;
          word_q <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(e))) begin
          arm_q  <= wr_arm;
          word_q <= wr_word;
        end
      end

      assign eq[e] = arm_q && (word_q == look_word);
    end
  endgenerate

  assign hit = |eq;
endmodule

// File: rtl/bkpt_stage_track.sv
module bkpt_stage_track
  import bkpt_halt_pkg::*;
#(
  parameter int N_STG = 4,
  localparam int MEM_IX = N_STG - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            take,
  input  logic [PC_W-1:0] take_pc,
  input  logic            take_bp,
  input  logic            dec_break,
  input  logic            kill,
  output logic            mem_valid,
  output logic [PC_W-1:0] mem_pc,
  output logic            mem_bp,
  output logic            mem_brk,
  output logic            wb_valid,
  output logic [PC_W-1:0] wb_pc,
  output logic            busy_front
);
  stage_t [MEM_IX:0] st;
  logic              wb_valid_q;
  logic [PC_W-1:0]   wb_pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= '0;
      wb_valid_q <= 1'b0;
      wb_pc_q    <= '0;
    end else if (kill) begin
      st <= '0;
      if (advance) wb_valid_q <= 1'b0;
    end else if (advance) begin
      st[0].valid <= take;
      st[0].pc    <= take_pc;
      st[0].bp    <= take && take_bp;
      st[0].brk   <= 1'b0;
      for (int k = 1; k <= MEM_IX; k++) st[k] <= st[k-1];
      st[1].brk   <= st[0].valid && (dec_break || st[0].brk);
      wb_valid_q  <= st[MEM_IX].valid;
      wb_pc_q     <= st[MEM_IX].pc;
    end
  end

  always_comb begin
    busy_front = 1'b0;
    for (int k = 0; k <= MEM_IX; k++) busy_front = busy_front | st[k].valid;
  end

  assign mem_valid = st[MEM_IX].valid;
  assign mem_pc    = st[MEM_IX].pc;
  assign mem_bp    = st[MEM_IX].bp;
  assign mem_brk   = st[MEM_IX].brk;
  assign wb_valid  = wb_valid_q;
  assign wb_pc     = wb_pc_q;
endmodule

// File: rtl/bkpt_halt_fsm.sv
module bkpt_halt_fsm
  import bkpt_halt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            hw_hit,
  input  logic            sw_hit,
  input  logic [PC_W-1:0] mem_pc,
  input  logic            mem_valid,
  input  logic            mem_dslot,
  input  logic [PC_W-1:0] mem_next_pc,
  input  logic            wb_valid,
  input  logic [PC_W-1:0] wb_pc,
  input  logic            busy_front,
  input  logic            take,
  input  logic            resume_req,
  input  logic            step_req,
  output logic            flush,
  output logic            fetch_hold,
  output logic            mask_once,
  output logic            halted,
  output logic [PC_W-1:0] restart_pc
);
  run_e            state_q;
  cause_e          cause_q;
  logic            step_mode_q, step_took_q, mask_q;
  logic [PC_W-1:0] restart_q, step_next_q;
  logic            wb_clears, step_done;

  assign flush     = (state_q == S_RUN) && (hw_hit || sw_hit);
  assign wb_clears = advance || !wb_valid;
  assign step_done = (state_q == S_RUN) && step_mode_q && step_took_q &&
                     !busy_front && wb_clears;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_RUN;
      cause_q     <= C_NONE;
      step_mode_q <= 1'b0;
      step_took_q <= 1'b0;
      mask_q      <= 1'b0;
      restart_q   <= '0;
      step_next_q <= '0;
    end else begin
      if (take) begin
        mask_q <= 1'b0;
        if (step_mode_q) step_took_q <= 1'b1;
      end
      if (step_mode_q && mem_valid && advance) step_next_q <= mem_next_pc;
      unique case (state_q)
        S_RUN: begin
          if (flush) begin
            if (hw_hit) begin
              restart_q <= mem_dslot ? wb_pc : mem_pc;
              cause_q   <= C_ADDR;
            end else begin
              restart_q <= mem_pc + PC_W'(4);
              cause_q   <= C_BREAK;
            end
            state_q     <= wb_clears ? S_HALT : S_DRAIN;
            step_mode_q <= 1'b0;
          end else if (step_done) begin
            restart_q   <= step_next_q;
            cause_q     <= C_STEP;
            state_q     <= S_HALT;
            step_mode_q <= 1'b0;
          end
        end
        S_DRAIN: if (wb_clears) state_q <= S_HALT;
        S_HALT: begin
          if (resume_req || step_req) begin
            state_q     <= S_RUN;
            mask_q      <= (cause_q == C_ADDR);
            step_mode_q <= !resume_req;
            step_took_q <= 1'b0;
          end
        end
        default: state_q <= S_RUN;
      endcase
    end
  end

  assign fetch_hold = (state_q != S_RUN) || flush || (step_mode_q && step_took_q);
  assign mask_once  = mask_q;
  assign halted     = (state_q == S_HALT);
  assign restart_pc = restart_q;
endmodule

// File: rtl/bkpt_halt_ctrl.sv
module bkpt_halt_ctrl
  import bkpt_halt_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int N_STG = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_wr_en,
  input  logic [IDX_W-1:0] tbl_wr_idx,
  input  logic [PC_W-3:0]  tbl_wr_word,
  input  logic             tbl_wr_arm,
  input  logic             fetch_valid,
  output logic             fetch_ready,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             advance,
  input  logic             id_break,
  input  logic             mem_dslot,
  input  logic [PC_W-1:0]  mem_next_pc,
  input  logic             resume_req,
  input  logic             step_req,
  output logic             mem_suppress,
  output logic             flush_young,
  output logic             halted,
  output logic [PC_W-1:0]  resume_pc
);
  logic            hit, take, fetch_hold, mask_once, flush;
  logic            mem_valid, mem_bp, mem_brk, wb_valid, busy_front;
  logic [PC_W-1:0] mem_pc, wb_pc;
  logic            hw_hit, sw_hit;

  bkpt_match_table #(.N_ENT(N_ENT)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_word(tbl_wr_word), .wr_arm(tbl_wr_arm),
    .look_word(fetch_pc[PC_W-1:2]), .hit(hit)
  );

  assign fetch_ready = advance && !fetch_hold;
  assign take        = fetch_valid && fetch_ready;

  bkpt_stage_track #(.N_STG(N_STG)) u_track (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .take(take), .take_pc(fetch_pc), .take_bp(hit && !mask_once),
    .dec_break(id_break), .kill(flush),
    .mem_valid(mem_valid), .mem_pc(mem_pc), .mem_bp(mem_bp), .mem_brk(mem_brk),
    .wb_valid(wb_valid), .wb_pc(wb_pc), .busy_front(busy_front)
  );

  assign hw_hit = mem_valid && mem_bp;
  assign sw_hit = mem_valid && mem_brk;

  bkpt_halt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .hw_hit(hw_hit), .sw_hit(sw_hit), .mem_pc(mem_pc), .mem_valid(mem_valid),
    .mem_dslot(mem_dslot), .mem_next_pc(mem_next_pc),
    .wb_valid(wb_valid), .wb_pc(wb_pc), .busy_front(busy_front), .take(take),
    .resume_req(resume_req), .step_req(step_req),
    .flush(flush), .fetch_hold(fetch_hold), .mask_once(mask_once),
    .halted(halted), .restart_pc(resume_pc)
  );

  assign mem_suppress = hw_hit;
  assign flush_young  = flush;
endmodule

// File: rtl/bkpt_halt_ctrl_chk.sv
module bkpt_halt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_ready,
  input logic        advance,
  input logic        mem_suppress,
  input logic        flush_young,
  input logic        halted,
  input logic        resume_req,
  input logic        step_req,
  input logic [31:0] resume_pc
);
  p_ready_needs_adv_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> advance);

  p_supp_flushes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_suppress |-> (flush_young && !fetch_ready));

  p_flush_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_young |=> !flush_young);

  p_halt_no_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !fetch_ready);

  p_halt_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !resume_req && !step_req) |=> halted);

  p_halt_leaves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && (resume_req || step_req)) |=> !halted);

  p_pc_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> $stable(resume_pc));
endmodule

bind bkpt_halt_ctrl bkpt_halt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready), .advance(advance),
  .mem_suppress(mem_suppress), .flush_young(flush_young), .halted(halted),
  .resume_req(resume_req), .step_req(step_req), .resume_pc(resume_pc)
);

// File: tb/tb_bkpt_halt_ctrl.sv
module tb_bkpt_halt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_wr_en, tbl_wr_arm;
  logic [1:0]  tbl_wr_idx;
  logic [29:0] tbl_wr_word;
  logic        fetch_valid, fetch_ready, advance, id_break, mem_dslot;
  logic [31:0] fetch_pc, mem_next_pc, resume_pc;
  logic        resume_req, step_req, mem_suppress, flush_young, halted;

  int  nchk = 0;
  int  nerr = 0;
  int  ncyc = 0;
  logic acc;

  always #5 clk = ~clk;

  bkpt_halt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_word(tbl_wr_word), .tbl_wr_arm(tbl_wr_arm), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_pc(fetch_pc), .advance(advance),
    .id_break(id_break), .mem_dslot(mem_dslot), .mem_next_pc(mem_next_pc),
    .resume_req(resume_req), .step_req(step_req), .mem_suppress(mem_suppress),
    .flush_young(flush_young), .halted(halted), .resume_pc(resume_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    #1;
    acc = fetch_valid && fetch_ready;
    @(posedge clk);
    #2;
    ncyc++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tbl_wr_en = 0; tbl_wr_arm = 0; tbl_wr_idx = 0; tbl_wr_word = 0;
    fetch_valid = 0; fetch_pc = 0; advance = 0; id_break = 0; mem_dslot = 0;
    mem_next_pc = 0; resume_req = 0; step_req = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic write_ent(input int idx, input logic [31:0] addr, input logic arm);
    tbl_wr_en = 1; tbl_wr_idx = 2'(idx); tbl_wr_word = addr[31:2]; tbl_wr_arm = arm;
    tick();
    tbl_wr_en = 0;
  endtask

  // Address-match stop over each entry, with and without delay slot
  task automatic hw_case(input int idx, input bit ds);
    logic [31:0] bp;
    int t_acc, t_sup, t_halt, t1, t2, n_acc;
    bp = 32'h200 + 32'(idx) * 32'h40;
    do_reset();
    for (int e = 0; e < 4; e++) write_ent(e, bp, e == idx);
    mem_dslot = ds; fetch_pc = bp - 16; fetch_valid = 1; advance = 1;
    t_acc = -100; t_sup = -1; t_halt = -1;
    for (int c = 0; c < 40 && t_halt < 0; c++) begin
      tick();
      if (acc && fetch_pc == bp) begin
        t_acc = ncyc;
        chk("R2 ready after tagged fetch", fetch_ready, 1);
      end
      if (acc) fetch_pc += 4;
      if (mem_suppress && t_sup < 0) begin
        t_sup = ncyc;
        chk("R3 flush with suppress", flush_young, 1);
        chk("R3 ready low at flush", fetch_ready, 0);
      end
      if (halted) t_halt = ncyc;
    end
    chk("R1/R2 suppress timing", t_sup, t_acc + 2);
    chk("R4 halt timing", t_halt, t_sup + 1);
    chk(ds ? "R5 restart at branch" : "R4 restart at tagged", resume_pc, ds ? bp - 4 : bp);
    for (int c = 0; c < 3; c++) begin
      tick();
      chk("R9 halt held", halted, 1);
      chk("R9 no fetch while halted", fetch_ready, 0);
    end
    resume_req = 1; tick(); resume_req = 0;
    chk("R9 leaves halt", halted, 0);
    fetch_pc = resume_pc;
    t1 = -1; t2 = -1; t_sup = -1; n_acc = 0;
    for (int c = 0; c < 20 && !halted; c++) begin
      tick();
      if (acc) begin
        n_acc++;
        if (n_acc == 1) begin t1 = ncyc; fetch_pc = bp; end
        else begin
          if (n_acc == 2) t2 = ncyc;
          fetch_pc += 4;
        end
      end
      if (mem_suppress && t_sup < 0) t_sup = ncyc;
    end
    chk("R6 first fetch masked, second tagged", t_sup, t2 + 2);
    chk("R6 second fetch follows first", t2, t1 + 1);
    chk("R6 halted again", halted, 1);
  endtask

  initial begin
    int t_sup, t_h, t_b, t_f, t_a, n_acc;
    logic seen_sup;

    // R10: reset state and cleared table
    do_reset();
    write_ent(1, 32'h100, 1);
    do_reset();
    advance = 1;
    #1;
    chk("R10 halted", halted, 0);
    chk("R10 flush", flush_young, 0);
    chk("R10 suppress", mem_suppress, 0);
    chk("R10 resume_pc", resume_pc, 0);
    chk("R12 ready with advance", fetch_ready, 1);
    advance = 0;
    #1;
    chk("R12 ready without advance", fetch_ready, 0);
    fetch_valid = 1; fetch_pc = 32'hF0;
    for (int c = 0; c < 3; c++) begin
      tick();
      chk("R12 no accept", acc, 0);
    end
    advance = 1; seen_sup = 0;
    for (int c = 0; c < 20; c++) begin
      tick();
      if (acc) fetch_pc += 4;
      if (mem_suppress || halted) seen_sup = 1;
    end
    chk("R10 table cleared by reset", seen_sup, 0);

    // R1..R6 sweep over entries and delay-slot setting
    for (int idx = 0; idx < 4; idx++)
      for (int ds = 0; ds < 2; ds++) hw_case(idx, ds[0]);

    // R11: unarmed entry and low PC bits
    do_reset();
    write_ent(0, 32'h300, 0);
    write_ent(3, 32'h30E, 1);
    fetch_pc = 32'h2F8; fetch_valid = 1; advance = 1;
    t_a = -100; t_sup = -1;
    for (int c = 0; c < 20 && t_sup < 0; c++) begin
      tick();
      if (acc && fetch_pc == 32'h30C) t_a = ncyc;
      if (acc) fetch_pc += 4;
      if (mem_suppress) t_sup = ncyc;
    end
    chk("R11 unarmed ignored, low bits ignored", t_sup, t_a + 2);
    tick();
    chk("R11 restart", resume_pc, 32'h30C);

    // R4: drain waits while advance is low
    do_reset();
    write_ent(0, 32'h600, 1);
    fetch_pc = 32'h5F0; fetch_valid = 1; advance = 1;
    t_sup = -1;
    for (int c = 0; c < 20 && t_sup < 0; c++) begin
      tick();
      if (acc) fetch_pc += 4;
      if (mem_suppress) t_sup = ncyc;
    end
    advance = 0;
    for (int c = 0; c < 3; c++) begin
      tick();
      chk("R4 waits for writeback", halted, 0);
      chk("R3 flush one cycle", flush_young, 0);
    end
    advance = 1;
    tick();
    chk("R4 halts after drain", halted, 1);
    chk("R4 restart after drain", resume_pc, 32'h600);

    // R7: break instruction
    do_reset();
    fetch_pc = 32'h400; fetch_valid = 1; advance = 1;
    t_b = -100; t_f = -1; t_h = -1; seen_sup = 0;
    for (int c = 0; c < 30 && t_h < 0; c++) begin
      tick();
      id_break = 0;
      if (acc && fetch_pc == 32'h410) begin t_b = ncyc; id_break = 1; end
      if (acc) fetch_pc += 4;
      if (flush_young && t_f < 0) t_f = ncyc;
      if (mem_suppress) seen_sup = 1;
      if (halted) t_h = ncyc;
    end
    chk("R7 flush at memory stage", t_f, t_b + 2);
    chk("R7 halt", t_h, t_b + 3);
    chk("R7 no suppress", seen_sup, 0);
    chk("R7 restart after break", resume_pc, 32'h414);

    // R8: two single steps
    for (int k = 0; k < 2; k++) begin
      step_req = 1; tick(); step_req = 0;
      fetch_pc = resume_pc;
      mem_next_pc = 32'h500 + 32'(k) * 32'h100;
      n_acc = 0; t_a = -100; t_h = -1;
      for (int c = 0; c < 20 && t_h < 0; c++) begin
        tick();
        if (acc) begin n_acc++; t_a = ncyc; fetch_pc += 4; end
        if (halted) t_h = ncyc;
      end
      chk("R8 one fetch", n_acc, 1);
      chk("R8 halt timing", t_h, t_a + 4);
      chk("R8 restart", resume_pc, mem_next_pc);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule